// File: doc/BRIEF.md
# Redundant Controller Fail-Over Arbiter

This block watches a chain of four local controllers that serve one converter phase. Each controller normally drives the two gate signals of its own half-bridge cell. Every pair of controllers in the chain has a persistence counter. The counter advances on each sample strobe where the two controllers' gate pairs differ, and it clears as soon as they agree. A controller that persistently disagrees with every other controller is flagged as failed. The flag stays set until reset.

For each failed cell, an adjacent healthy controller is chosen to take over, and its gate pair is routed to the orphaned cell's outputs. A cell with no usable neighbour is an orphan: it is held in the bypass state and the phase is reported down. A final guard on every cell output stops the upper and lower switch from being driven on together.

Top module: `ctrl_failover_arb`

## Requirements
- R1: While reset is asserted and after it is released, no controller is flagged, no cell is taken over, `phase_up` is 1, and each cell's gate pair equals its own controller's pair.
- R2: For each pair of controllers, a counter increments on every `sample_stb` where the two gate pairs differ, saturating at its maximum. It clears to 0 on any strobe where the pairs agree. The pair counts as in error only while the counter is strictly greater than `mismatch_limit`.
- R3: A controller is flagged in `ctrl_failed` when all of its pair counters against the other controllers are in error at once. The flag appears on the second rising clock edge after the strobe that pushed the last of those counters over the limit.
- R4: A failed flag stays set until reset, even after the controller's outputs agree again.
- R5: A failed cell is taken over only by an adjacent controller (index one lower or one higher) that is not flagged. The lower one is preferred. No controller takes over more than one extra cell. Cells are allocated in rising index order. The assignment appears on `cell_rescued` and `cell_rescuer` one clock edge after the flag.
- R6: Gate bit 2c drives the upper switch of cell c and bit 2c+1 drives the lower switch; the controller input pairs use the same layout. A healthy cell outputs its own controller's pair. A taken-over cell outputs its rescuer's pair.
- R7: A failed cell that has no rescuer is driven to bypass, with the upper bit 0 and the lower bit 1, and `phase_up` is 0 while any such cell exists. A flagged cell whose assignment is not yet registered is also driven to bypass.
- R8: No cell's gate pair is ever 11. A routed pair of 11 is replaced by the bypass pattern.
- R9: The limit is taken live from `mismatch_limit`. With a limit of 0, a single mismatching strobe puts a pair in error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_stb | input | 1 | One-cycle strobe marking a comparison sample |
| mismatch_limit | input | CNT_W | Persistence limit for pair mismatch counters |
| ctrl_pwm | input | 2*N_CTRL | Gate pairs from all controllers, bit 2i upper, 2i+1 lower |
| gate_out | output | 2*N_CTRL | Gate pairs to the cells, same layout |
| ctrl_failed | output | N_CTRL | Sticky failed flag per controller |
| cell_rescued | output | N_CTRL | Cell is served by a neighbouring controller |
| cell_rescuer | output | N_CTRL*IDX_W | Index of the serving neighbour, IDX_W bits per cell |
| phase_up | output | 1 | 0 while any cell is orphaned |

## Verification
Two controllers can cross the persistence limit on the same strobe. Their flags then rise in one cycle, and the allocator must settle both cells in the same pass, including who gets the shared neighbour and whether an orphan appears. The bench provokes this with simultaneous double faults that use distinct corrupted patterns, covering the recoverable and the orphaning combinations. Every cycle, a behavioural model of flags, assignment and gate routing is compared against the outputs. Routing and the shoot-through guard also meet in one cycle when a rescuer's pattern is 11. Both are judged on the same gate comparison.

// File: rtl/fo_arb_pkg.sv
package fo_arb_pkg;
  // bit 0: upper switch, bit 1: lower switch
  typedef logic [1:0] sw_pair_t;
  localparam sw_pair_t PAIR_BYPASS = 2'b10;
  localparam sw_pair_t PAIR_SHOOT  = 2'b11;

  function automatic sw_pair_t safe_pair(input sw_pair_t p);
    return (p == PAIR_SHOOT) ? PAIR_BYPASS : p;
  endfunction
endpackage

// File: rtl/fo_pair_monitor.sv
module fo_pair_monitor
  import fo_arb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  sw_pair_t         pwm_a,
  input  sw_pair_t         pwm_b,
  input  logic [CNT_W-1:0] limit,
  output logic             persist_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             differ;

  always_comb begin
    differ = (pwm_a != pwm_b);
    if (!differ)               cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (sample_stb) cnt_q <= cnt_d;
  end

  assign persist_err = (cnt_q > limit);

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (pwm_a == pwm_b)) |=> (cnt_q == '0 && !persist_err));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (pwm_a != pwm_b) && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/fo_takeover_alloc.sv
module fo_takeover_alloc #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       failed,
  output logic [N-1:0]       rescued_q,
  output logic [N*IDX_W-1:0] rescuer_q,
  output logic [N-1:0]       orphan_q
);
  logic [N-1:0]       used, resc_d, orph_d;
  logic [N*IDX_W-1:0] who_d;

  always_comb begin
    used   = '0;
    resc_d = '0;
    orph_d = '0;
    who_d  = '0;
    for (int c = 0; c < N; c++) begin
      if (failed[c]) begin
        if ((c > 0) && !failed[c-1] && !used[c-1]) begin
          resc_d[c] = 1'b1;
          used[c-1] = 1'b1;
          who_d[c*IDX_W +: IDX_W] = IDX_W'(c - 1);
        end else if ((c < N-1) && !failed[c+1] && !used[c+1]) begin
          resc_d[c] = 1'b1;
          used[c+1] = 1'b1;
          who_d[c*IDX_W +: IDX_W] = IDX_W'(c + 1);
        end else begin
          orph_d[c] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rescued_q <= '0;
      rescuer_q <= '0;
      orphan_q  <= '0;
    end else begin
      rescued_q <= resc_d;
      rescuer_q <= who_d;
      orphan_q  <= orph_d;
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_adj
    // R5
    rescuer_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rescued_q[c] |-> ((int'(rescuer_q[c*IDX_W +: IDX_W]) == c - 1) ||
                        (int'(rescuer_q[c*IDX_W +: IDX_W]) == c + 1)));
  end

  for (genvar r = 0; r < N; r++) begin : g_use
    logic [N-1:0] hit;
    for (genvar c = 0; c < N; c++) begin : g_cell
      assign hit[c] = rescued_q[c] && (int'(rescuer_q[c*IDX_W +: IDX_W]) == r);
    end
    // R5
    single_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit) <= 1);
  end
endmodule

// File: rtl/fo_gate_router.sv
module fo_gate_router
  import fo_arb_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [2*N-1:0]     ctrl_pwm,
  input  logic [N-1:0]       failed,
  input  logic [N-1:0]       rescued,
  input  logic [N*IDX_W-1:0] rescuer,
  output logic [2*N-1:0]     gate_out
);
  always_comb begin
    gate_out = '0;
    for (int c = 0; c < N; c++) begin
      sw_pair_t sel;
      int       src;
      src = int'(rescuer[c*IDX_W +: IDX_W]);
      sel = ctrl_pwm[2*c +: 2];
      if (failed[c]) begin
        sel = rescued[c] ? ctrl_pwm[2*src +: 2] : PAIR_BYPASS;
      end
      gate_out[2*c +: 2] = safe_pair(sel);
    end
  end
endmodule

// File: rtl/ctrl_failover_arb.sv
module ctrl_failover_arb
  import fo_arb_pkg::*;
#(
  parameter  int N_CTRL = 4,
  parameter  int CNT_W  = 8,
  localparam int IDX_W  = (N_CTRL > 1) ? $clog2(N_CTRL) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_stb,
  input  logic [CNT_W-1:0]        mismatch_limit,
  input  logic [2*N_CTRL-1:0]     ctrl_pwm,
  output logic [2*N_CTRL-1:0]     gate_out,
  output logic [N_CTRL-1:0]       ctrl_failed,
  output logic [N_CTRL-1:0]       cell_rescued,
  output logic [N_CTRL*IDX_W-1:0] cell_rescuer,
  output logic                    phase_up
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic err_mat [N_CTRL][N_CTRL];

  for (genvar a = 0; a < N_CTRL; a++) begin : g_row
    assign err_mat[a][a] = 1'b1;
    for (genvar b = a + 1; b < N_CTRL; b++) begin : g_col
      logic pair_err;
      fo_pair_monitor #(.CNT_W(CNT_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .sample_stb (sample_stb),
        .pwm_a      (ctrl_pwm[2*a +: 2]),
        .pwm_b      (ctrl_pwm[2*b +: 2]),
        .limit      (mismatch_limit),
        .persist_err(pair_err)
      );
      assign err_mat[a][b] = pair_err;
      assign err_mat[b][a] = pair_err;
    end
  end

  logic [N_CTRL-1:0] dis_all, failed_d, failed_q;

  always_comb begin
    for (int k = 0; k < N_CTRL; k++) begin
      dis_all[k] = 1'b1;
      for (int j = 0; j < N_CTRL; j++) begin
        dis_all[k] = dis_all[k] & err_mat[k][j];
      end
    end
    failed_d = failed_q | dis_all;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) failed_q <= '0;
    else            failed_q <= failed_d;
  end

  logic [N_CTRL-1:0] orphan_q;

  fo_takeover_alloc #(.N(N_CTRL), .IDX_W(IDX_W)) u_alloc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .failed   (failed_q),
    .rescued_q(cell_rescued),
    .rescuer_q(cell_rescuer),
    .orphan_q (orphan_q)
  );

  fo_gate_router #(.N(N_CTRL), .IDX_W(IDX_W)) u_route (
    .ctrl_pwm(ctrl_pwm),
    .failed  (failed_q),
    .rescued (cell_rescued),
    .rescuer (cell_rescuer),
    .gate_out(gate_out)
  );

  assign ctrl_failed = failed_q;
  assign phase_up    = ~|orphan_q;

  // R4
  failed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((failed_q & $past(failed_q)) == $past(failed_q)));

  for (genvar c = 0; c < N_CTRL; c++) begin : g_guard
    // R8
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      gate_out[2*c +: 2] != PAIR_SHOOT);
    // R7
    orphan_bypass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      orphan_q[c] |-> (gate_out[2*c +: 2] == PAIR_BYPASS));
  end
endmodule

// File: tb/ctrl_failover_arb_bench.sv
module ctrl_failover_arb_bench;
  localparam int N  = 4;
  localparam int IW = 2;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #10 clk = ~clk;

  logic          sample_stb = 1'b0;
  logic [CW-1:0] mismatch_limit = 8'd3;
  logic [2*N-1:0] ctrl_pwm = '0;
  logic [2*N-1:0] gate_out;
  logic [N-1:0]   ctrl_failed, cell_rescued;
  logic [N*IW-1:0] cell_rescuer;
  logic           phase_up;

  ctrl_failover_arb u_ctrl_failover_arb (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .mismatch_limit(mismatch_limit), .ctrl_pwm(ctrl_pwm),
    .gate_out(gate_out), .ctrl_failed(ctrl_failed),
    .cell_rescued(cell_rescued), .cell_rescuer(cell_rescuer),
    .phase_up(phase_up)
  );

  int checks = 0, fails = 0, cyc = 0, step = 0;
  bit cmp_en = 0, done = 0, force11 = 0;
  logic [1:0] fcode [N];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int  rc [N][N];
  bit  rf [N], rr [N], ro [N], taken [N], nf [N];
  int  rw [N];
  int  ecount, pick;
  bit  bad;

  function automatic logic [1:0] heal_pat(input int s);
    case (s % 3)
      0: return 2'b01;
      1: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecount = 0;
      for (int a = 0; a < N; a++) begin
        rf[a] = 0; rr[a] = 0; ro[a] = 0; rw[a] = 0;
        for (int b = 0; b < N; b++) rc[a][b] = 0;
      end
    end else begin
      ecount++;
      if (ecount >= 3) begin
        for (int c = 0; c < N; c++) begin taken[c] = 0; rr[c] = 0; ro[c] = 0; rw[c] = 0; end
        for (int c = 0; c < N; c++) begin
          if (rf[c]) begin
            pick = -1;
            if (c >= 1 && !rf[c-1] && !taken[c-1]) pick = c - 1;
            else if (c + 1 < N && !rf[c+1] && !taken[c+1]) pick = c + 1;
            if (pick < 0) ro[c] = 1;
            else begin rr[c] = 1; rw[c] = pick; taken[pick] = 1; end
          end
        end
        for (int k = 0; k < N; k++) begin
          bad = 1;
          for (int j = 0; j < N; j++)
            if (j != k && !(rc[k][j] > int'(mismatch_limit))) bad = 0;
          nf[k] = rf[k] | bad;
        end
        for (int k = 0; k < N; k++) rf[k] = nf[k];
        if (sample_stb) begin
          for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
              if (a != b) begin
                if (ctrl_pwm[2*a +: 2] != ctrl_pwm[2*b +: 2])
                  rc[a][b] = (rc[a][b] >= 255) ? 255 : rc[a][b] + 1;
                else
                  rc[a][b] = 0;
              end
        end
      end
    end
  end

  logic [2*N-1:0] eg, ew, aw, wmask;
  logic [N-1:0]   ef, er;
  logic [1:0]     sel2;
  bit             eo;

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      eg = '0; ew = '0; ef = '0; er = '0; wmask = '0; eo = 0;
      for (int c = 0; c < N; c++) begin
        ef[c] = rf[c];
        er[c] = rr[c];
        if (ro[c]) eo = 1;
        if (rr[c]) begin
          ew[2*c +: 2] = 2'(rw[c]);
          wmask[2*c +: 2] = 2'b11;
        end
        sel2 = ctrl_pwm[2*c +: 2];
        if (rf[c]) sel2 = rr[c] ? ctrl_pwm[2*rw[c] +: 2] : 2'b10;
        if (sel2 == 2'b11) sel2 = 2'b10;
        eg[2*c +: 2] = sel2;
      end
      aw = cell_rescuer & wmask;
      chk(gate_out == eg, "R6 model gate", 32'(gate_out), 32'(eg));
      chk(ctrl_failed == ef, "R3 model flags", 32'(ctrl_failed), 32'(ef));
      chk(cell_rescued == er, "R5 model rescued", 32'(cell_rescued), 32'(er));
      chk(aw == ew, "R5 model rescuer", 32'(aw), 32'(ew));
      chk(phase_up == !eo, "R7 model phase", 32'(phase_up), 32'(!eo));
    end
  end

  // ---------------- stimulus ----------------
  task automatic apply_pwm();
    for (int k = 0; k < N; k++)
      ctrl_pwm[2*k +: 2] = force11 ? 2'b11 : (heal_pat(step) ^ fcode[k]);
  endtask

  task automatic do_sample(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      step++;
      apply_pwm();
      sample_stb = 1'b1;
      @(posedge clk); #1;
      sample_stb = 1'b0;
      repeat (2) @(posedge clk);
    end
  endtask

  task automatic reset_dut();
    @(posedge clk); #1;
    rst_n = 1'b0;
    force11 = 0;
    for (int k = 0; k < N; k++) fcode[k] = 2'b00;
    step = 0;
    apply_pwm();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic expect_state(input string tag, input logic [N-1:0] f, input logic [N-1:0] r,
                              input logic [2*N-1:0] who, input logic up);
    logic [2*N-1:0] m;
    @(negedge clk);
    m = '0;
    for (int c = 0; c < N; c++) if (r[c]) m[2*c +: 2] = 2'b11;
    chk(ctrl_failed == f, {tag, " flags"}, 32'(ctrl_failed), 32'(f));
    chk(cell_rescued == r, {tag, " rescued"}, 32'(cell_rescued), 32'(r));
    chk((cell_rescuer & m) == who, {tag, " rescuer"}, 32'(cell_rescuer & m), 32'(who));
    chk(phase_up == up, {tag, " phase"}, 32'(phase_up), 32'(up));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < N; k++) fcode[k] = 2'b00;
    #5 rst_n = 1'b0;
    reset_dut();
    cmp_en = 1;

    // R1: reset state
    expect_state("R1 reset", 4'b0000, 4'b0000, 8'h00, 1'b1);
    @(negedge clk);
    chk(gate_out == ctrl_pwm, "R1 gates pass own pair", 32'(gate_out), 32'(ctrl_pwm));

    // R8: all controllers emit 11, no mismatch, gates forced to bypass
    @(posedge clk); #1;
    force11 = 1; apply_pwm();
    do_sample(2);
    @(negedge clk);
    chk(gate_out == 8'b10101010, "R8 shoot-through guard", 32'(gate_out), 32'hAA);
    force11 = 0;

    // R2: ctrl1 disagrees for 3 samples (limit 3), agrees once, 3 more
    fcode[1] = 2'b10;
    do_sample(3);
    expect_state("R2 at limit", 4'b0000, 4'b0000, 8'h00, 1'b1);
    fcode[1] = 2'b00;
    do_sample(1);
    fcode[1] = 2'b10;
    do_sample(3);
    expect_state("R2 cleared by agree", 4'b0000, 4'b0000, 8'h00, 1'b1);
    // R3/R5: fourth consecutive mismatch crosses the limit
    do_sample(1);
    expect_state("R3 single middle", 4'b0010, 4'b0010, 8'h00, 1'b1);
    @(negedge clk);
    chk(gate_out[3:2] == ctrl_pwm[1:0], "R6 cell1 routed from ctrl0", 32'(gate_out[3:2]), 32'(ctrl_pwm[1:0]));
    chk(gate_out[1:0] == ctrl_pwm[1:0], "R6 cell0 own pair", 32'(gate_out[1:0]), 32'(ctrl_pwm[1:0]));
    // R4: controller recovers but stays flagged
    fcode[1] = 2'b00;
    do_sample(5);
    expect_state("R4 sticky", 4'b0010, 4'b0010, 8'h00, 1'b1);

    // R5: end controller taken over by its only neighbour
    reset_dut();
    fcode[0] = 2'b01;
    do_sample(6);
    expect_state("R5 edge single", 4'b0001, 4'b0001, 8'h01, 1'b1);

    // R5: two middle failures, one per side
    reset_dut();
    fcode[1] = 2'b01; fcode[2] = 2'b10;
    do_sample(6);
    expect_state("R5 double middle", 4'b0110, 4'b0110, 8'h30, 1'b1);

    // R5: cells 0 and 2; ctrl1 used by cell0, cell2 goes upward
    reset_dut();
    fcode[0] = 2'b01; fcode[2] = 2'b10;
    do_sample(6);
    expect_state("R5 alternate", 4'b0101, 4'b0101, 8'h31, 1'b1);

    // R5: both ends
    reset_dut();
    fcode[0] = 2'b01; fcode[3] = 2'b10;
    do_sample(6);
    expect_state("R5 both ends", 4'b1001, 4'b1001, 8'h81, 1'b1);

    // R7: lower pair orphans cell0
    reset_dut();
    fcode[0] = 2'b01; fcode[1] = 2'b10;
    do_sample(6);
    expect_state("R7 low orphan", 4'b0011, 4'b0010, 8'h08, 1'b0);
    @(negedge clk);
    chk(gate_out[1:0] == 2'b10, "R7 cell0 bypass", 32'(gate_out[1:0]), 32'h2);

    // R7: upper pair orphans cell3
    reset_dut();
    fcode[2] = 2'b01; fcode[3] = 2'b10;
    do_sample(6);
    expect_state("R7 high orphan", 4'b1100, 4'b0100, 8'h10, 1'b0);
    @(negedge clk);
    chk(gate_out[7:6] == 2'b10, "R7 cell3 bypass", 32'(gate_out[7:6]), 32'h2);

    // R9: limit 0 trips on a single mismatching sample
    reset_dut();
    mismatch_limit = 8'd0;
    fcode[3] = 2'b11;
    do_sample(1);
    expect_state("R9 limit zero", 4'b1000, 4'b1000, 8'h80, 1'b1);
    mismatch_limit = 8'd3;

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule